// File: doc/BRIEF.md
# CPU Space Cycle Responder

This block sits on the external bus of a 32-bit processor and answers the special bus cycles the processor runs in its CPU address space. During such a cycle the address lines carry a cycle type and cycle-specific fields instead of a memory address. The responder reads these fields and ends the cycle in the way each kind of cycle needs.

A breakpoint acknowledge cycle carries a breakpoint number. The responder looks that number up in an eight-slot table. Each slot holds a 16-bit replacement instruction word and a valid flag, and is loaded through a separate synchronous write port. If the slot is valid, the responder acknowledges the cycle and drives the word so that it replaces the breakpoint opcode. If the slot is empty, the responder ends the cycle with a bus error, which the processor treats as an illegal instruction. When the block is told to act as an 8-bit port, the word is returned in two byte cycles: the high byte first, then the low byte.

A coprocessor cycle carries a coprocessor number and an interface register select. The responder turns these into a one-hot chip select for up to seven coprocessors and a 5-bit register select. The selected coprocessor then completes the cycle. Any other CPU-space cycle ends with a bus error. A retry mode adds halt to every bus error the block gives, which asks the processor to run the cycle again.

Top module: `cpu_space_responder`

## Requirements
- R1: While reset is asserted and after it is released, with no strobe, data_o, ack_o, berr_o, halt_o, cp_sel_o and cp_reg_o are all zero.
- R2: A cycle with cpu_space_i=1, rd_i=1, addr_i[19:16]=0 and a valid slot, with port8_i=0, gives ack_o=1 and data_o equal to the stored 16-bit word at the first clock edge that samples strobe_i high. berr_o and halt_o stay 0.
- R3: The breakpoint number on addr_i[4:2] selects the table slot. A clock edge with tbl_we_i=1 stores tbl_word_i and tbl_valid_i into slot tbl_idx_i, and a later write to the slot replaces both.
- R4: A breakpoint cycle (type 0) whose slot is not valid, or that is a write (rd_i=0), gives berr_o=1 and ack_o=0, with data_o=0.
- R5: With port8_i=1, a breakpoint hit returns a single byte on data_o[15:8], with data_o[7:0]=0. addr_i[0]=0 returns the high byte of the word and addr_i[0]=1 returns the low byte.
- R6: A cycle with addr_i[19:16]=2 and coprocessor number addr_i[15:13] from 1 to 7 sets only cp_sel_o bit (number-1) and sets cp_reg_o=addr_i[4:0], for either rd_i value. ack_o and berr_o stay 0.
- R7: A coprocessor cycle with number 0 asserts no cp_sel_o bit and is ended with berr_o=1.
- R8: A CPU-space cycle with any type value other than 0 or 2 is ended with berr_o=1, ack_o=0, one clock edge after strobe_i is sampled high.
- R9: With retry_i=1, every bus error the block gives carries halt_o=1. halt_o is never 1 without berr_o, ack_o and berr_o are never 1 together, and a breakpoint hit still gives ack_o with halt_o=0.
- R10: The response taken at the first sampled edge is held unchanged while strobe_i stays high. All outputs return to zero at the first clock edge that samples strobe_i low.
- R11: A strobe with cpu_space_i=0 is not answered: all outputs stay zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | 32 | Bus address; in CPU space it carries type and fields |
| cpu_space_i | input | 1 | High when the function code marks a CPU-space cycle |
| strobe_i | input | 1 | Address strobe, active high |
| rd_i | input | 1 | 1 = read cycle, 0 = write cycle |
| port8_i | input | 1 | 1 = answer as an 8-bit port, 0 = as a 16-bit port |
| retry_i | input | 1 | 1 = add halt to every bus error (retry request) |
| tbl_we_i | input | 1 | Breakpoint table write enable |
| tbl_idx_i | input | 3 | Breakpoint table slot to write |
| tbl_word_i | input | 16 | Instruction word to store |
| tbl_valid_i | input | 1 | Valid flag to store |
| data_o | output | 16 | Returned instruction word or byte |
| ack_o | output | 1 | Data acknowledge |
| berr_o | output | 1 | Bus error |
| halt_o | output | 1 | Halt, given only together with bus error |
| cp_sel_o | output | 7 | One-hot coprocessor chip selects, bit n-1 for number n |
| cp_reg_o | output | 5 | Coprocessor interface register select |

## Verification
The assertions assume that address, qualifier, direction, port size and retry inputs stay stable while strobe_i is high. They also assume that the breakpoint table is not written during an active strobe. The stimulus changes these inputs only on falling clock edges, and only while strobe_i is low. Each strobe is held for two rising edges and then dropped for at least one edge, so the hold and release checks always see a full cycle. Table writes happen only between cycles.

// File: rtl/cpusp_pkg.sv
package cpusp_pkg;
  localparam int ADDR_W     = 32;
  localparam int WORD_W     = 16;
  localparam int NUM_BKPT   = 8;
  localparam int BKPT_IDX_W = $clog2(NUM_BKPT);
  localparam int NUM_CP     = 7;
  localparam int CP_ID_W    = 3;
  localparam int CP_REG_W   = 5;
  localparam int TYPE_W     = 4;

  localparam logic [TYPE_W-1:0] TYPE_BKPT   = 4'h0;
  localparam logic [TYPE_W-1:0] TYPE_COPROC = 4'h2;

  typedef enum logic [2:0] {
    CLS_IGNORE,
    CLS_BKPT_HIT,
    CLS_BKPT_MISS,
    CLS_COPROC,
    CLS_REJECT
  } cls_e;

  function automatic logic [TYPE_W-1:0] f_cyc_type(input logic [ADDR_W-1:0] a);
    return a[19:16];
  endfunction

  function automatic logic [BKPT_IDX_W-1:0] f_bkpt_num(input logic [ADDR_W-1:0] a);
    return a[4:2];
  endfunction

  function automatic logic [CP_ID_W-1:0] f_cp_id(input logic [ADDR_W-1:0] a);
    return a[15:13];
  endfunction

  function automatic logic [CP_REG_W-1:0] f_cp_reg(input logic [ADDR_W-1:0] a);
    return a[4:0];
  endfunction

  // Number 0 selects nothing; number n lights bit n-1.
  function automatic logic [NUM_CP-1:0] f_cp_onehot(input logic [CP_ID_W-1:0] id);
    logic [NUM_CP-1:0] r;
    r = '0;
    if (id != '0) r[int'(id) - 1] = 1'b1;
    return r;
  endfunction

  // 16-bit port returns the word; 8-bit port returns one byte on the upper lane.
  function automatic logic [WORD_W-1:0] f_byte_lane(input logic [WORD_W-1:0] w,
                                                    input logic port8,
                                                    input logic a0);
    logic [WORD_W-1:0] r;
    if (!port8)  r = w;
    else if (a0) r = {w[WORD_W/2-1:0], {(WORD_W/2){1'b0}}};
    else         r = {w[WORD_W-1:WORD_W/2], {(WORD_W/2){1'b0}}};
    return r;
  endfunction
endpackage

// File: rtl/cpusp_bkpt_table.sv
module cpusp_bkpt_table #(
  parameter int N  = cpusp_pkg::NUM_BKPT,
  parameter int W  = cpusp_pkg::WORD_W,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [W-1:0]  wr_word_i,
  input  logic          wr_valid_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [W-1:0]  rd_word_o,
  output logic          rd_valid_o
);
  logic [W-1:0] word_q [N];
  logic         vld_q  [N];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        word_q[i] <= '0;
        vld_q[i]  <= 1'b0;
      end
    end else if (we_i) begin
      word_q[wr_idx_i] <= wr_word_i;
      vld_q[wr_idx_i]  <= wr_valid_i;
    end
  end

  assign rd_word_o  = word_q[rd_idx_i];
  assign rd_valid_o = vld_q[rd_idx_i];

  // R3: a write lands in the addressed slot by the next edge.
  a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (vld_q[$past(wr_idx_i)] == $past(wr_valid_i)) &&
             (word_q[$past(wr_idx_i)] == $past(wr_word_i)));
endmodule

// File: rtl/cpusp_decode.sv
module cpusp_decode
  import cpusp_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          cpu_space_i,
  input  logic          rd_i,
  input  logic [AW-1:0] addr_i,
  input  logic          slot_valid_i,
  output cls_e          cls_o
);
  logic [TYPE_W-1:0]  cyc_type;
  logic [CP_ID_W-1:0] cp_id;

  assign cyc_type = f_cyc_type(addr_i);
  assign cp_id    = f_cp_id(addr_i);

  always_comb begin
    cls_o = CLS_IGNORE;
    if (cpu_space_i) begin
      if (cyc_type == TYPE_BKPT) begin
        if (!rd_i)             cls_o = CLS_REJECT;
        else if (slot_valid_i) cls_o = CLS_BKPT_HIT;
        else                   cls_o = CLS_BKPT_MISS;
      end else if (cyc_type == TYPE_COPROC) begin
        cls_o = (cp_id == '0) ? CLS_REJECT : CLS_COPROC;
      end else begin
        cls_o = CLS_REJECT;
      end
    end
  end
endmodule

// File: rtl/cpusp_resp.sv
module cpusp_resp
  import cpusp_pkg::*;
#(
  parameter int W  = WORD_W,
  parameter int NC = NUM_CP
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                strobe_i,
  input  cls_e                cls_i,
  input  logic [W-1:0]        word_i,
  input  logic                port8_i,
  input  logic                a0_i,
  input  logic [CP_ID_W-1:0]  cp_id_i,
  input  logic [CP_REG_W-1:0] cp_reg_i,
  input  logic                retry_i,
  output logic [W-1:0]        data_o,
  output logic                ack_o,
  output logic                berr_o,
  output logic                halt_o,
  output logic [NC-1:0]       cp_sel_o,
  output logic [CP_REG_W-1:0] cp_reg_o
);
  logic done_q;
  logic take_evt;   // first edge of a strobe that belongs to this block
  logic drop_evt;   // strobe seen low: release everything

  assign take_evt = strobe_i && !done_q && (cls_i != CLS_IGNORE);
  assign drop_evt = !strobe_i;

  always_ff @(posedge clk) begin
    if (!rst_n || drop_evt) begin
      done_q   <= 1'b0;
      data_o   <= '0;
      ack_o    <= 1'b0;
      berr_o   <= 1'b0;
      halt_o   <= 1'b0;
      cp_sel_o <= '0;
      cp_reg_o <= '0;
    end else if (take_evt) begin
      done_q <= 1'b1;
      case (cls_i)
        CLS_BKPT_HIT: begin
          ack_o  <= 1'b1;
          data_o <= f_byte_lane(word_i, port8_i, a0_i);
        end
        CLS_COPROC: begin
          cp_sel_o <= f_cp_onehot(cp_id_i);
          cp_reg_o <= cp_reg_i;
        end
        default: begin
          berr_o <= 1'b1;
          halt_o <= retry_i;
        end
      endcase
    end
  end

  // R9: acknowledge and bus error never together.
  a_r9_ack_berr_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack_o && berr_o));
  // R9: halt only rides on a bus error.
  a_r9_halt_needs_berr: assert property (@(posedge clk) disable iff (!rst_n)
    halt_o |-> berr_o);
  // R10: everything released after the strobe is seen low.
  a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_i |=> (!ack_o && !berr_o && !halt_o && cp_sel_o == '0 && data_o == '0));
  // R10: a given acknowledge is held while the strobe stays high.
  a_r10_ack_held: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && strobe_i) |=> (ack_o && $stable(data_o)));
  // R6: at most one coprocessor selected.
  a_r6_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cp_sel_o));
  // R6: a coprocessor select never comes with acknowledge or bus error.
  a_r6_sel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_sel_o != '0) |-> (!ack_o && !berr_o));
  // R2: an acknowledge only rises after a sampled strobe.
  a_r2_ack_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_o) |-> $past(strobe_i));
endmodule

// File: rtl/cpu_space_responder.sv
module cpu_space_responder
  import cpusp_pkg::*;
#(
  parameter int AW  = ADDR_W,
  parameter int W   = WORD_W,
  parameter int NB  = NUM_BKPT,
  parameter int NC  = NUM_CP,
  localparam int IW = $clog2(NB)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [AW-1:0]       addr_i,
  input  logic                cpu_space_i,
  input  logic                strobe_i,
  input  logic                rd_i,
  input  logic                port8_i,
  input  logic                retry_i,
  input  logic                tbl_we_i,
  input  logic [IW-1:0]       tbl_idx_i,
  input  logic [W-1:0]        tbl_word_i,
  input  logic                tbl_valid_i,
  output logic [W-1:0]        data_o,
  output logic                ack_o,
  output logic                berr_o,
  output logic                halt_o,
  output logic [NC-1:0]       cp_sel_o,
  output logic [CP_REG_W-1:0] cp_reg_o
);
  logic [W-1:0] slot_word;
  logic         slot_valid;
  cls_e         cls;
  logic         unused_addr_bits;

  assign unused_addr_bits = ^{addr_i[AW-1:20], addr_i[12:5]};

  cpusp_bkpt_table #(.N(NB), .W(W)) u_table (
    .clk        (clk),
    .rst_n      (rst_n),
    .we_i       (tbl_we_i),
    .wr_idx_i   (tbl_idx_i),
    .wr_word_i  (tbl_word_i),
    .wr_valid_i (tbl_valid_i),
    .rd_idx_i   (f_bkpt_num(addr_i)),
    .rd_word_o  (slot_word),
    .rd_valid_o (slot_valid)
  );

  cpusp_decode #(.AW(AW)) u_decode (
    .cpu_space_i  (cpu_space_i),
    .rd_i         (rd_i),
    .addr_i       (addr_i),
    .slot_valid_i (slot_valid),
    .cls_o        (cls)
  );

  cpusp_resp #(.W(W), .NC(NC)) u_resp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe_i (strobe_i),
    .cls_i    (cls),
    .word_i   (slot_word),
    .port8_i  (port8_i),
    .a0_i     (addr_i[0]),
    .cp_id_i  (f_cp_id(addr_i)),
    .cp_reg_i (f_cp_reg(addr_i)),
    .retry_i  (retry_i),
    .data_o   (data_o),
    .ack_o    (ack_o),
    .berr_o   (berr_o),
    .halt_o   (halt_o),
    .cp_sel_o (cp_sel_o),
    .cp_reg_o (cp_reg_o)
  );

  // R11: a strobe outside CPU space never produces a response.
  a_r11_ignore_plain: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_i && !cpu_space_i && !ack_o && !berr_o && cp_sel_o == '0)
      |=> (!ack_o && !berr_o && cp_sel_o == '0));
  // R7: coprocessor number 0 never selects.
  a_r7_id0_no_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_i && cpu_space_i && addr_i[19:16] == 4'h2 && addr_i[15:13] == 3'd0 &&
     !berr_o) |=> (cp_sel_o == '0));
endmodule

// File: tb/cpu_space_responder_tb.sv
module cpu_space_responder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] addr;
  logic        cpu, strb, rd, p8, retry;
  logic        twe, tvld;
  logic [2:0]  tidx;
  logic [15:0] tword;
  logic [15:0] data_o;
  logic        ack_o, berr_o, halt_o;
  logic [6:0]  sel_o;
  logic [4:0]  reg_o;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [15:0] data;
    logic        ack, berr, halt;
    logic [6:0]  sel;
    logic [4:0]  rsel;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  event mon_ev;

  logic [15:0] sh_word [8];
  logic        sh_vld  [8];

  always #4 clk = ~clk;

  cpu_space_responder dut_i (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .cpu_space_i(cpu), .strobe_i(strb),
    .rd_i(rd), .port8_i(p8), .retry_i(retry), .tbl_we_i(twe), .tbl_idx_i(tidx),
    .tbl_word_i(tword), .tbl_valid_i(tvld), .data_o(data_o), .ack_o(ack_o),
    .berr_o(berr_o), .halt_o(halt_o), .cp_sel_o(sel_o), .cp_reg_o(reg_o)
  );

  task automatic check(input logic ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  task automatic cmp_outputs(input exp_t e);
    check(data_o == e.data, e.tag, "data", 32'(data_o), 32'(e.data));
    check(ack_o  == e.ack,  e.tag, "ack",  32'(ack_o),  32'(e.ack));
    check(berr_o == e.berr, e.tag, "berr", 32'(berr_o), 32'(e.berr));
    check(halt_o == e.halt, e.tag, "halt", 32'(halt_o), 32'(e.halt));
    check(sel_o  == e.sel,  e.tag, "sel",  32'(sel_o),  32'(e.sel));
    check(reg_o  == e.rsel, e.tag, "reg",  32'(reg_o),  32'(e.rsel));
  endtask

  // Monitor: pops one expected item per response and compares.
  always @(mon_ev) begin
    exp_t e;
    e = exp_q.pop_front();
    cmp_outputs(e);
  end

  function automatic logic [31:0] bk_addr(input logic [2:0] n, input logic a0);
    return {12'h000, 4'h0, 11'h000, n, 1'b0, a0};
  endfunction

  function automatic logic [31:0] cp_addr(input logic [2:0] id, input logic [4:0] r);
    return {12'h000, 4'h2, id, 8'h00, r};
  endfunction

  function automatic logic [31:0] ty_addr(input logic [3:0] t);
    return {12'h000, t, 16'h0000};
  endfunction

  // Independent model built from the requirement text.
  function automatic exp_t model(input logic [31:0] a, input logic c, input logic r,
                                 input logic b8, input logic rt, input string tag);
    exp_t e;
    e.data = '0; e.ack = 0; e.berr = 0; e.halt = 0; e.sel = '0; e.rsel = '0; e.tag = tag;
    if (c) begin
      if (a[19:16] == 4'd0 && r && sh_vld[a[4:2]]) begin
        e.ack = 1;
        if (!b8)      e.data = sh_word[a[4:2]];
        else if (a[0]) e.data = {sh_word[a[4:2]][7:0], 8'h00};
        else           e.data = {sh_word[a[4:2]][15:8], 8'h00};
      end else if (a[19:16] == 4'd2 && a[15:13] != 3'd0) begin
        e.sel  = 7'b1 << (a[15:13] - 3'd1);
        e.rsel = a[4:0];
      end else begin
        e.berr = 1;
        e.halt = rt;
      end
    end
    return e;
  endfunction

  task automatic tbl_write(input logic [2:0] i, input logic [15:0] w, input logic v);
    @(negedge clk);
    twe = 1; tidx = i; tword = w; tvld = v;
    @(negedge clk);
    twe = 0;
    sh_word[i] = w; sh_vld[i] = v;
  endtask

  task automatic run_cyc(input logic [31:0] a, input logic c, input logic r,
                         input logic b8, input logic rt, input string tag);
    exp_t e, z;
    e = model(a, c, r, b8, rt, tag);
    @(negedge clk);
    addr = a; cpu = c; rd = r; p8 = b8; retry = rt; strb = 1;
    @(negedge clk);                  // one rising edge has sampled the strobe
    exp_q.push_back(e);
    ->mon_ev;
    @(negedge clk);                  // second edge: response must be held (R10)
    e.tag = {tag, "/R10-hold"};
    cmp_outputs(e);
    strb = 0;
    @(negedge clk);                  // edge sampling strobe low: released (R10)
    z = model(a, 1'b0, r, b8, rt, {tag, "/R10-release"});
    cmp_outputs(z);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    exp_t z;
    for (int i = 0; i < 8; i++) begin sh_word[i] = '0; sh_vld[i] = 0; end
    rst_n = 0; addr = '0; cpu = 0; strb = 0; rd = 1; p8 = 0; retry = 0;
    twe = 0; tidx = '0; tword = '0; tvld = 0;
    repeat (3) @(negedge clk);
    z = model(32'h0, 1'b0, 1'b1, 1'b0, 1'b0, "R1-in-reset");
    cmp_outputs(z);
    rst_n = 1;
    @(negedge clk);
    z.tag = "R1-after-reset";
    cmp_outputs(z);

    tbl_write(3'd0, 16'h4E71, 1'b1);
    tbl_write(3'd3, 16'hA5C3, 1'b1);
    tbl_write(3'd7, 16'h1234, 1'b1);
    tbl_write(3'd5, 16'hFFFF, 1'b0);

    run_cyc(bk_addr(3'd0, 1'b0), 1, 1, 0, 0, "R2-hit-slot0");
    run_cyc(bk_addr(3'd3, 1'b0), 1, 1, 0, 0, "R3-slot3");
    run_cyc(bk_addr(3'd7, 1'b0), 1, 1, 0, 0, "R3-slot7");
    run_cyc(bk_addr(3'd5, 1'b0), 1, 1, 0, 0, "R4-invalid-slot5");
    run_cyc(bk_addr(3'd2, 1'b0), 1, 1, 0, 0, "R4-unwritten-slot2");
    run_cyc(bk_addr(3'd0, 1'b0), 1, 0, 0, 0, "R4-write-cycle");
    run_cyc(bk_addr(3'd3, 1'b0), 1, 1, 1, 0, "R5-byte-high");
    run_cyc(bk_addr(3'd3, 1'b1), 1, 1, 1, 0, "R5-byte-low");
    run_cyc(bk_addr(3'd7, 1'b1), 1, 1, 1, 0, "R5-byte-low-slot7");
    run_cyc(cp_addr(3'd1, 5'h0A), 1, 1, 0, 0, "R6-cp1");
    run_cyc(cp_addr(3'd7, 5'h1F), 1, 1, 0, 0, "R6-cp7");
    run_cyc(cp_addr(3'd4, 5'h03), 1, 0, 0, 0, "R6-cp4-write");
    run_cyc(cp_addr(3'd0, 5'h05), 1, 1, 0, 0, "R7-cp0");
    run_cyc(ty_addr(4'h5), 1, 1, 0, 0, "R8-type5");
    run_cyc(ty_addr(4'hF), 1, 1, 0, 0, "R8-typeF");
    run_cyc(ty_addr(4'h5), 1, 1, 0, 1, "R9-retry-type5");
    run_cyc(bk_addr(3'd5, 1'b0), 1, 1, 0, 1, "R9-retry-miss");
    run_cyc(cp_addr(3'd0, 5'h00), 1, 1, 0, 1, "R9-retry-cp0");
    run_cyc(bk_addr(3'd0, 1'b0), 1, 1, 0, 1, "R9-retry-hit-no-halt");
    run_cyc(bk_addr(3'd0, 1'b0), 0, 1, 0, 0, "R11-not-cpu-space");
    run_cyc(ty_addr(4'h5), 0, 1, 0, 0, "R11-not-cpu-space-type5");
    tbl_write(3'd5, 16'hBEEF, 1'b1);
    run_cyc(bk_addr(3'd5, 1'b0), 1, 1, 0, 0, "R3-rewrite-slot5");
    tbl_write(3'd0, 16'h0000, 1'b0);
    run_cyc(bk_addr(3'd0, 1'b0), 1, 1, 0, 0, "R3-clear-slot0");

    repeat (2) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule